// File: doc/BRIEF.md
# X-Tolerant XOR Response Compactor

This block reduces many scan-chain response bits to a few compacted bits during test unload. In every scan-out cycle it takes one response bit from each of `NUM_CHAINS` chains. A network of XOR gates, fixed by a binary matrix parameter with one row per chain and one column per output, turns those bits into `NUM_OUTS` compacted bits. Every chain bit carries an unknown flag. An output is unknown when any chain that feeds it is unknown, and such an output is never compared.

A registered checker next to the network builds the expected compacted word from the expected chain bits through the same matrix. In each valid cycle it compares that word with the compacted response on the known outputs only. It raises a per-output mismatch bit and a sticky fail bit. A synchronous clear, asserted at the start of each pattern's unload, resets the fail bit.

The matrix rows must be nonzero, pairwise distinct and of odd weight. An elaboration check rejects any matrix that breaks one of these rules. The default matrix gives row `i` the `i`-th three-column subset of the outputs, taken in lexicographic order. For example, with six outputs row 0 sets columns 0, 1 and 2, and row 1 sets columns 0, 1 and 3.

Top module: `xcomp_top`

## Requirements
- R1: `compData[j]` is, in the same cycle, the XOR of every `chainData[i]` whose matrix entry (i, j) is 1. The entry (i, j) is held at bit `i*NUM_OUTS + j` of `XC_MATRIX`.
- R2: `compX[j]` is, in the same cycle, the OR of every `chainX[i]` whose matrix entry (i, j) is 1. It is 0 whenever no chain is unknown.
- R3: One cycle after a cycle with `cycleValid` high, `misMatch[j]` is 1 exactly when `compX[j]` was 0 and `compData[j]` differed from the XOR of the matching `expData` bits.
- R4: One cycle after a cycle with `cycleValid` low, `misMatch` is all zero, whatever the data and flags were.
- R5: `failSticky` goes to 1 in the cycle after any mismatch is found. It then stays at 1 until a clear.
- R6: When `clear` is high, the next `failSticky` equals the mismatch result of that same cycle. A clear therefore never hides a mismatch that arrives together with it.
- R7: While `rstN` is low, `misMatch` and `failSticky` are 0.
- R8: With the default matrix and no unknown chain, any one, two or three erroneous chain bits in a valid cycle set at least one `misMatch` bit.
- R9: With the default matrix, one erroneous chain together with one unknown chain in the same valid cycle sets at least one `misMatch` bit.
- R10: With the default matrix and no unknown chain, any odd number of erroneous chain bits in a valid cycle sets at least one `misMatch` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous clear of the sticky fail bit |
| cycleValid | input | 1 | The current scan-out cycle is to be compared |
| chainData | input | NUM_CHAINS | Response bit from each chain |
| chainX | input | NUM_CHAINS | Unknown flag for each chain bit |
| expData | input | NUM_CHAINS | Expected response bit for each chain |
| compData | output | NUM_OUTS | Compacted response |
| compX | output | NUM_OUTS | Unknown flag for each compacted bit |
| misMatch | output | NUM_OUTS | Registered mismatch on known outputs |
| failSticky | output | 1 | Sticky fail bit |

## Verification
The assertions check the cycle-level rules on every cycle. They cover quiet mismatch bits after invalid cycles, the rule that unknown outputs never report a mismatch, a fail bit that holds without a clear and follows the mismatch word on a clear, and clean compacted flags when no chain is unknown. The detection guarantees hold only for the right data patterns, so only the bench's scenarios can show them. These scenarios are every single error, chosen double, triple and five-bit errors, and every pair of one error with one unknown chain, each checked against a model that computes the matrix on its own.

// File: rtl/xcomp_pkg.sv
package xcomp_pkg;

  localparam int MAX_BITS = 4096;

  typedef struct packed {
    logic compare;
    logic clearFail;
  } ctlStrobes_t;

  // Row r holds the r-th 3-subset of columns in lexicographic order.
  function automatic logic [MAX_BITS-1:0] genMatrix(int nRows, int nCols);
    logic [MAX_BITS-1:0] mat;
    int r;
    mat = '0;
    r = 0;
    for (int a = 0; a < nCols; a++)
      for (int b = a + 1; b < nCols; b++)
        for (int c = b + 1; c < nCols; c++) begin
          if (r < nRows) begin
            mat[r*nCols + a] = 1'b1;
            mat[r*nCols + b] = 1'b1;
            mat[r*nCols + c] = 1'b1;
          end
          r++;
        end
    return mat;
  endfunction

  // Rows must be nonzero, odd weight and pairwise distinct.
  function automatic bit matrixOk(logic [MAX_BITS-1:0] mat, int nRows, int nCols);
    bit ok;
    ok = 1'b1;
    for (int r = 0; r < nRows; r++) begin
      int weight;
      weight = 0;
      for (int c = 0; c < nCols; c++) weight += int'(mat[r*nCols + c]);
      if (weight == 0 || (weight % 2) == 0) ok = 1'b0;
      for (int s = r + 1; s < nRows; s++) begin
        bit same;
        same = 1'b1;
        for (int c = 0; c < nCols; c++)
          if (mat[r*nCols + c] != mat[s*nCols + c]) same = 1'b0;
        if (same) ok = 1'b0;
      end
    end
    return ok;
  endfunction

endpackage

// File: rtl/xcomp_ctrl.sv
module xcomp_ctrl (
  input  logic                    cycleValid,
  input  logic                    clear,
  output xcomp_pkg::ctlStrobes_t  strobes
);

  always_comb begin
    strobes.compare   = cycleValid;
    strobes.clearFail = clear;
  end

endmodule

// File: rtl/xcomp_datapath.sv
module xcomp_datapath #(
  parameter int NUM_CHAINS = 12,
  parameter int NUM_OUTS   = 6,
  parameter logic [NUM_CHAINS*NUM_OUTS-1:0] XC_MATRIX = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xcomp_pkg::ctlStrobes_t strobes,
  input  logic [NUM_CHAINS-1:0]  chainData,
  input  logic [NUM_CHAINS-1:0]  chainX,
  input  logic [NUM_CHAINS-1:0]  expData,
  output logic [NUM_OUTS-1:0]    compData,
  output logic [NUM_OUTS-1:0]    compX,
  output logic [NUM_OUTS-1:0]    misMatch,
  output logic                   failSticky
);

  logic [NUM_OUTS-1:0] expComp;
  logic [NUM_OUTS-1:0] cmpHit;
  logic                anyHit;

  for (genvar j = 0; j < NUM_OUTS; j++) begin : g_col
    always_comb begin
      compData[j] = 1'b0;
      compX[j]    = 1'b0;
      expComp[j]  = 1'b0;
      for (int i = 0; i < NUM_CHAINS; i++) begin
        if (XC_MATRIX[i*NUM_OUTS + j]) begin
          compData[j] = compData[j] ^ chainData[i];
          expComp[j]  = expComp[j] ^ expData[i];
          compX[j]    = compX[j] | chainX[i];
        end
      end
    end
  end

  always_comb begin
    cmpHit = strobes.compare ? ((compData ^ expComp) & ~compX) : '0;
    anyHit = |cmpHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misMatch   <= '0;
      failSticky <= 1'b0;
    end else begin
      misMatch   <= cmpHit;
      failSticky <= (failSticky & ~strobes.clearFail) | anyHit;
    end
  end

endmodule

// File: rtl/xcomp_top.sv
module xcomp_top #(
  parameter int NUM_CHAINS = 12,
  parameter int NUM_OUTS   = 6,
  parameter logic [NUM_CHAINS*NUM_OUTS-1:0] XC_MATRIX =
    (NUM_CHAINS*NUM_OUTS)'(xcomp_pkg::genMatrix(NUM_CHAINS, NUM_OUTS))
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clear,
  input  logic                  cycleValid,
  input  logic [NUM_CHAINS-1:0] chainData,
  input  logic [NUM_CHAINS-1:0] chainX,
  input  logic [NUM_CHAINS-1:0] expData,
  output logic [NUM_OUTS-1:0]   compData,
  output logic [NUM_OUTS-1:0]   compX,
  output logic [NUM_OUTS-1:0]   misMatch,
  output logic                  failSticky
);

  localparam int MAT_BITS = NUM_CHAINS * NUM_OUTS;
  localparam bit MAT_OK =
    xcomp_pkg::matrixOk(xcomp_pkg::MAX_BITS'(XC_MATRIX), NUM_CHAINS, NUM_OUTS);

  if (MAT_BITS > xcomp_pkg::MAX_BITS || !MAT_OK) begin : g_badMatrix
    $error("xcomp_top: matrix has a zero, even-weight or repeated row");
  end

  xcomp_pkg::ctlStrobes_t strobes;

  xcomp_ctrl ctrl_i (
    .cycleValid (cycleValid),
    .clear      (clear),
    .strobes    (strobes)
  );

  xcomp_datapath #(
    .NUM_CHAINS (NUM_CHAINS),
    .NUM_OUTS   (NUM_OUTS),
    .XC_MATRIX  (XC_MATRIX)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .chainData  (chainData),
    .chainX     (chainX),
    .expData    (expData),
    .compData   (compData),
    .compX      (compX),
    .misMatch   (misMatch),
    .failSticky (failSticky)
  );

endmodule

// File: rtl/xcomp_checker.sv
module xcomp_checker #(
  parameter int NUM_CHAINS = 12,
  parameter int NUM_OUTS   = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clear,
  input logic                  cycleValid,
  input logic [NUM_CHAINS-1:0] chainX,
  input logic [NUM_OUTS-1:0]   compX,
  input logic [NUM_OUTS-1:0]   misMatch,
  input logic                  failSticky
);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |=> (misMatch == '0));

  a_r3_x_masked: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |=> ((misMatch & $past(compX)) == '0));

  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (failSticky && !clear) |=> failSticky);

  a_r5_sticky_set: assert property (@(posedge clk) disable iff (!rstN)
    (|misMatch) |-> failSticky);

  a_r6_clear_follows: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (failSticky == (|misMatch)));

  a_r2_no_x_clean: assert property (@(posedge clk) disable iff (!rstN)
    (chainX == '0) |-> (compX == '0));

endmodule

bind xcomp_top xcomp_checker #(
  .NUM_CHAINS (NUM_CHAINS),
  .NUM_OUTS   (NUM_OUTS)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .clear      (clear),
  .cycleValid (cycleValid),
  .chainX     (chainX),
  .compX      (compX),
  .misMatch   (misMatch),
  .failSticky (failSticky)
);

// File: tb/xcomp_top_tb_top.sv
`timescale 1ns/1ps
module xcomp_top_tb_top;

  localparam int N = 12;
  localparam int M = 6;

  typedef struct {
    logic [M-1:0] mis;
    logic         fail;
    bit           mustDetect;
    string        tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic cycleValid = 1'b0;
  logic [N-1:0] chainData = '0;
  logic [N-1:0] chainX = '0;
  logic [N-1:0] expData = '0;
  logic [M-1:0] compData, compX, misMatch;
  logic failSticky;

  int chkCnt = 0;
  int failCnt = 0;
  expItem_t sbQ[$];
  logic modelFail = 1'b0;
  bit tbMat[N][M];

  always #2.5 clk = ~clk;

  xcomp_top #(.NUM_CHAINS(N), .NUM_OUTS(M)) dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .cycleValid(cycleValid),
    .chainData(chainData), .chainX(chainX), .expData(expData),
    .compData(compData), .compX(compX), .misMatch(misMatch),
    .failSticky(failSticky)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [M-1:0] compOf(logic [N-1:0] v);
    logic [M-1:0] r = '0;
    for (int j = 0; j < M; j++)
      for (int i = 0; i < N; i++)
        if (tbMat[i][j]) r[j] ^= v[i];
    return r;
  endfunction

  // Drives one scan-out cycle, checks the combinational outputs, queues the registered result.
  task automatic drive(logic [N-1:0] exp, logic [N-1:0] err, logic [N-1:0] xf,
                       logic vld, logic clr, bit mustDetect, string tag);
    expItem_t it;
    logic [M-1:0] xe, mis;
    @(negedge clk);
    expData = exp; chainData = exp ^ err; chainX = xf;
    cycleValid = vld; clear = clr;
    #0.5;
    xe = '0;
    for (int j = 0; j < M; j++)
      for (int i = 0; i < N; i++)
        if (tbMat[i][j]) xe[j] |= xf[i];
    check(compData == compOf(exp ^ err), {"R1 ", tag}, 32'(compData), 32'(compOf(exp ^ err)));
    check(compX == xe, {"R2 ", tag}, 32'(compX), 32'(xe));
    mis = vld ? ((compOf(exp ^ err) ^ compOf(exp)) & ~xe) : '0;
    modelFail = (clr ? 1'b0 : modelFail) | (|mis);
    it.mis = mis; it.fail = modelFail; it.mustDetect = mustDetect; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: compares registered outputs just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #0.5;
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        check(misMatch == it.mis, {"R3 misMatch ", it.tag}, 32'(misMatch), 32'(it.mis));
        check(failSticky == it.fail, {"R5 failSticky ", it.tag}, 32'(failSticky), 32'(it.fail));
        if (it.mustDetect)
          check(misMatch != '0, {"detect ", it.tag}, 32'(misMatch), 32'(1));
      end
    end
  end

  initial begin
    #1_000_000;
    chkCnt++; failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

  initial begin
    int r;
    r = 0;
    for (int i = 0; i < N; i++) for (int j = 0; j < M; j++) tbMat[i][j] = 0;
    for (int a = 0; a < M; a++)
      for (int b = a + 1; b < M; b++)
        for (int c = b + 1; c < M; c++) begin
          if (r < N) begin tbMat[r][a] = 1; tbMat[r][b] = 1; tbMat[r][c] = 1; end
          r++;
        end

    repeat (3) @(posedge clk);
    #0.5;
    check(misMatch == '0, "R7 reset misMatch", 32'(misMatch), 0);
    check(failSticky == 1'b0, "R7 reset failSticky", 32'(failSticky), 0);
    @(negedge clk) rstN = 1'b1;

    drive(12'hA5C, '0, '0, 1, 1, 0, "clean compare");
    for (int i = 0; i < N; i++)
      drive(12'(($urandom() % 4096)), 12'(1) << i, '0, 1, 1, 1, "R8 single error");
    for (int i = 0; i < N; i++)
      for (int k = i + 1; k < N; k += 3)
        drive(12'h3C9, (12'(1) << i) | (12'(1) << k), '0, 1, 1, 1, "R8 double error");
    drive(12'h0F0, 12'b0000_0000_0111, '0, 1, 1, 1, "R8 triple error");
    drive(12'h0F0, 12'b1001_0000_0001, '0, 1, 1, 1, "R8 triple error spread");
    drive(12'h777, 12'b1010_1010_1000, '0, 1, 1, 1, "R10 five errors");
    drive(12'h123, 12'b1111_1110_0000, '0, 1, 1, 1, "R10 seven errors");
    for (int i = 0; i < N; i++)
      for (int k = 0; k < N; k++)
        if (k != i)
          drive(12'h5A5, 12'(1) << i, 12'(1) << k, 1, 1, 1, "R9 error with one X");
    drive(12'h5A5, 12'h0FF, 12'hF00, 1, 1, 0, "R3 masked by X");
    drive(12'h5A5, 12'h00F, '0, 0, 1, 0, "R4 invalid cycle ignored");
    drive(12'h5A5, 12'h001, '0, 1, 0, 1, "R5 set fail");
    drive(12'h5A5, '0, '0, 1, 0, 0, "R5 fail holds");
    drive(12'h5A5, '0, '0, 0, 0, 0, "R5 fail holds idle");
    drive(12'h5A5, 12'h002, '0, 1, 1, 1, "R6 clear with mismatch");
    drive(12'h5A5, '0, '0, 1, 1, 0, "R6 clear without mismatch");
    drive(12'h5A5, '0, '0, 0, 0, 0, "R6 stays clear");
    @(posedge clk); #1;

    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

endmodule